// File: doc/BRIEF.md
# Four-Channel Auto-Reload PWM Timer

This block is a 12-bit up-counting timer that drives four pulse-width-modulated outputs sharing one period. The counter climbs to its all-ones value, and then an overflow event reloads it from a programmable start value. That start value therefore fixes both the PWM period and the number of distinct duty steps: a low start value gives a long period with fine steps, and a high start value gives a short period with coarse steps.

Software writes a start value, four duty values, and one control word through a simple synchronous write port. A combinational read port returns the written values. Duty values land in preload registers and only reach the comparators at the next overflow, so no period ever mixes an old duty setting with a new one. Each channel has an output enable and an inversion bit. A transfer-mode bit chooses whether an inversion change waits for the next overflow or takes effect at once. Inversion also gives a constant-high output, because a duty value at or below the start value keeps the uninverted output low for the whole period.

Address map: 0 is the start (reload) value. 1 to 4 are the duty values for channels 0 to 3. 5 is the control word, with bits [3:0] the output enables for channels 0 to 3, bits [7:4] the inversion bits for channels 0 to 3, and bit 8 the transfer mode (1 = synchronized to overflow). Other addresses read as 0.

Top module: `quad_reload_pwm`

## Requirements
- R1: During and after reset the counter is 0, all active duty values are 0, all enables and inversion bits are 0, and the transfer-mode bit is 1. The outputs are therefore all 0, and address 5 reads 0x100.
- R2: The counter advances by one per clock. In the clock after it holds 4095 it loads the reload value. The first overflow after reset therefore drives a channel high on the 4096th clock, and each later period lasts 4096 minus the reload value clocks.
- R3: An enabled, non-inverted channel is high from the overflow until the counter equals its active duty value. It is then low through count 4095, which gives duty minus reload high clocks per period.
- R4: A write to a duty address (1 to 4) changes only the preload copy. The active value, and with it the output, changes at the next overflow and not before.
- R5: When a channel's active duty value is less than or equal to the reload value, the non-inverted output stays 0 for the whole period and the inverted output stays 1.
- R6: A channel whose enable bit (control bits [3:0]) is 0 drives 0 whatever its inversion bit.
- R7: With transfer mode 1 (control bit 8), a written inversion bit (control bits [7:4]) takes effect only at the next overflow.
- R8: With transfer mode 0, a written inversion bit takes effect in the clock after the write.
- R9: The read port returns, for the addressed register, the reload value, the preload duty values, or the control word as written (enables [3:0], inversion [7:4], mode [8]).
- R10: A new reload value has no effect on the period in progress. It sets the start count from the next overflow on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 12 | Register read data, combinational |
| pwm_o | output | 4 | PWM outputs, channel 0 in bit 0 |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a period. It has to be shown that the period in progress is untouched while the next one changes, or, with transfer mode 0, that the current period changes at once. The ports show no overflow. The stimulus therefore keeps channel 1 at duty 4095 as a marker, so that its rising edge marks every overflow. It then issues the write in the first clock after such an edge, while counting the high clocks of channel 0 and the clocks in the period across that period and the next. The same marker counts the 4096 clocks to the first overflow after reset.

// File: rtl/quad_reload_pwm.sv
module quad_reload_pwm #(
  parameter int CW  = 12,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_o
);
  localparam logic [CW-1:0] TOP   = '1;
  localparam logic [AW-1:0] A_RLD = '0;
  localparam logic [AW-1:0] A_CTL = AW'(NCH + 1);
  localparam int            MODE  = 2 * NCH;

  logic [CW-1:0]  cnt, rld;
  logic [CW-1:0]  duty_pre [NCH];
  logic [CW-1:0]  duty_act [NCH];
  logic [NCH-1:0] en, pol_pre, pol_act, pol_eff, raw;
  logic           sync_mode;
  logic           ctl_unused;

  wire ovf    = (cnt == TOP);
  wire wr_ctl = wr_en && (wr_addr == A_CTL);

  assign ctl_unused = ^wr_data[CW-1:MODE+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (ovf) cnt <= rld;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld <= '0;
    else if (wr_en && wr_addr == A_RLD) rld <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= '0;
      pol_pre   <= '0;
      sync_mode <= 1'b1;
    end else if (wr_ctl) begin
      en        <= wr_data[NCH-1:0];
      pol_pre   <= wr_data[MODE-1:NCH];
      sync_mode <= wr_data[MODE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_act <= '0;
    else if (!sync_mode || ovf) pol_act <= pol_pre;
  end

  assign pol_eff = sync_mode ? pol_act : pol_pre;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_pre[ch] <= '0;
        duty_act[ch] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(ch + 1)) duty_pre[ch] <= wr_data;
        if (ovf) duty_act[ch] <= duty_pre[ch];
      end
    end

    assign raw[ch] = (cnt < duty_act[ch]);

    AST_DUTY_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> duty_act[ch] == $past(duty_pre[ch])); // R4
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf |=> $stable(duty_act[ch])); // R4
  end

  assign pwm_o = en & (raw ^ pol_eff);

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_RLD) rd_data = rld;
    if (rd_addr == A_CTL) begin
      rd_data[NCH-1:0]    = en;
      rd_data[MODE-1:NCH] = pol_pre;
      rd_data[MODE]       = sync_mode;
    end
    for (int i = 0; i < NCH; i++)
      if (rd_addr == AW'(i + 1)) rd_data = duty_pre[i];
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt == $past(rld)); // R10
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !ovf) |=> $stable(pol_act)); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wr_data[NCH-1:0] == '0) |=> pwm_o == '0); // R6
endmodule

// File: tb/quad_reload_pwm_tb.sv
module quad_reload_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic [3:0]  pwm_o;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  quad_reload_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  // {reload, duty0, inv0, en0, expected high clocks of channel 0}
  localparam logic [38:0] VEC [0:8] = '{
    {12'd4000, 12'd4050, 1'b0, 1'b1, 13'd50},   // R3
    {12'd4000, 12'd4095, 1'b0, 1'b1, 13'd95},   // R3
    {12'd4000, 12'd4000, 1'b0, 1'b1, 13'd0},    // R5
    {12'd4000, 12'd3000, 1'b1, 1'b1, 13'd96},   // R5
    {12'd4000, 12'd4010, 1'b1, 1'b1, 13'd86},   // R3
    {12'd0,    12'd2048, 1'b0, 1'b1, 13'd2048}, // R3
    {12'd4094, 12'd4095, 1'b0, 1'b1, 13'd1},    // R2
    {12'd3900, 12'd3950, 1'b0, 1'b1, 13'd50},   // R2
    {12'd4000, 12'd4050, 1'b1, 1'b0, 13'd0}     // R6
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input int exp);
    rd_addr = a;
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  // channel 1 is held at duty 4095, so each rising edge marks an overflow
  task automatic measure(input bit sync, input bit do_wr, input logic [3:0] a,
                         input logic [11:0] d, output int per, output int hi);
    logic prev;
    int guard;
    prev = pwm_o[1];
    guard = 0;
    if (sync) begin
      forever begin
        @(negedge clk);
        guard++;
        if ((!prev && pwm_o[1]) || guard > 9000) break;
        prev = pwm_o[1];
      end
    end
    per = 0;
    hi = 0;
    forever begin
      per++;
      hi += int'(pwm_o[0]);
      if (do_wr && per == 1) begin
        wr_en = 1'b1; wr_addr = a; wr_data = d;
      end else wr_en = 1'b0;
      prev = pwm_o[1];
      @(negedge clk);
      if ((!prev && pwm_o[1]) || per > 9000) break;
    end
    wr_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int per, hi, n;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", int'(pwm_o), 0);
    rd_chk("R1 control after reset", 4'd5, 'h100);
    rd_chk("R1 reload after reset", 4'd0, 0);
    rst_n = 1'b1;
    chk("R1 outputs after reset", int'(pwm_o), 0);
    rd_chk("R1 duty after reset", 4'd1, 0);

    wr(4'd2, 12'd4095);
    wr(4'd5, 12'h102);
    n = 2;
    while (!pwm_o[1] && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R2 clocks to first overflow", n, 4096);

    for (int i = 0; i < 9; i++) begin
      logic [38:0] v;
      v = VEC[i];
      wr(4'd0, v[38:27]);
      wr(4'd1, v[26:15]);
      wr(4'd5, 12'h102 | {7'd0, v[14], 3'd0, v[13]});
      measure(1'b1, 1'b0, 4'd0, 12'd0, per, hi);
      chk($sformatf("R3 row %0d high clocks", i), hi, int'(v[12:0]));
      chk($sformatf("R2 row %0d period", i), per, 4096 - int'(v[38:27]));
    end

    wr(4'd0, 12'd4000);
    wr(4'd1, 12'd4050);
    wr(4'd5, 12'h103);
    measure(1'b1, 1'b0, 4'd0, 12'd0, per, hi);
    chk("R3 settle high", hi, 50);
    measure(1'b0, 1'b1, 4'd1, 12'd4020, per, hi);
    chk("R4 duty write mid period", hi, 50);
    rd_chk("R9 duty preload read", 4'd1, 4020);
    measure(1'b0, 1'b0, 4'd0, 12'd0, per, hi);
    chk("R4 duty after overflow", hi, 20);

    measure(1'b0, 1'b1, 4'd0, 12'd3950, per, hi);
    chk("R10 period during reload write", per, 96);
    rd_chk("R9 reload read", 4'd0, 3950);
    measure(1'b0, 1'b0, 4'd0, 12'd0, per, hi);
    chk("R10 period after overflow", per, 146);
    chk("R10 high after overflow", hi, 70);

    wr(4'd0, 12'd4000);
    wr(4'd1, 12'd4050);
    measure(1'b1, 1'b0, 4'd0, 12'd0, per, hi);
    measure(1'b0, 1'b1, 4'd5, 12'h113, per, hi);
    chk("R7 synced inversion period", hi, 50);
    rd_chk("R9 control read", 4'd5, 'h113);
    measure(1'b0, 1'b0, 4'd0, 12'd0, per, hi);
    chk("R7 inversion after overflow", hi, 46);

    measure(1'b0, 1'b1, 4'd5, 12'h103, per, hi);
    measure(1'b0, 1'b0, 4'd0, 12'd0, per, hi);
    chk("R7 inversion cleared at overflow", hi, 50);
    measure(1'b0, 1'b1, 4'd5, 12'h013, per, hi);
    chk("R8 immediate inversion on", hi, 47);
    measure(1'b0, 1'b0, 4'd0, 12'd0, per, hi);
    chk("R8 inverted full period", hi, 46);
    measure(1'b0, 1'b1, 4'd5, 12'h003, per, hi);
    chk("R8 immediate inversion off", hi, 49);

    wr(4'd5, 12'h0F0);
    chk("R6 all disabled while inverted", int'(pwm_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule